// File: doc/BRIEF.md
# Minute-Day Clock with Offset-Tracking Alarm

This block keeps wall time as two counters: a minute-of-day value from 0 to 1439 and a day count that stops at 4095. A one-cycle strobe is expected once per real minute. The block does not keep seconds or hours. Software reaches the time through a small window of 4-bit entries, and each multi-nybble value is stored least significant nybble first.

A latch request takes a snapshot of both counters into the scratch part of the window, all at once. A load request copies the scratch part back into the counters, also all at once. Before a load, software can edit the scratch nybbles. On a load, the block also moves the stored alarm time by the same amount as the clock moved. The distance from the current time to the alarm therefore stays the same. Ordinary minute ticks never move the alarm. The alarm acts as a countdown target that the user cannot skip by setting the clock ahead.

Window layout:

| Address | Contents |
|---------|----------|
| 0–2 | Scratch minute |
| 3–5 | Scratch day |
| 6–8 | Alarm minute |
| 9–11 | Alarm day |

Each field is 12 bits, least significant nybble at the lowest address.

Top module: `mdc_clock`

## Requirements
- R1: Out of reset, the minute and day counters are 0 and every window entry reads 0. Each tick adds one to the minute counter, and the minute counter never exceeds 1439.
- R2: A tick while the minute counter is 1439 sets the minute counter to 0 and adds one to the day counter.
- R3: The day counter stops at 4095. A tick at minute 1439 of day 4095 wraps the minute counter to 0 and leaves the day at 4095.
- R4: A latch request writes the minute counter to addresses 0–2 and the day counter to addresses 3–5, least significant nybble first. The snapshot uses the counter values from before that cycle's edge, and a tick in the same cycle still advances the clock.
- R5: A write stores a 4-bit value at an address from 0 to 11, and a read returns it combinationally. Addresses 12–15 always read 0, and writes to them have no effect.
- R6: A load request sets the counters from addresses 0–5. A scratch minute value of 1440 or more is loaded as 1439.
- R7: On a load, the alarm changes by the difference between the new time and the old time. Minute overflow or underflow carries into or borrows from the alarm day, at 1440 minutes per day. The alarm day wraps modulo 4096.
- R8: The alarm entries (addresses 6–11) change only through window writes or a load. Ticks and latches leave them unchanged.
- R9: A tick in the same cycle as a load is dropped, and the loaded value wins.
- R10: A latch in the same cycle as a load is ignored, so the scratch entries keep the values that were just loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per elapsed minute |
| latch_i | input | 1 | Snapshot the counters into the scratch entries |
| load_i | input | 1 | Load the counters from scratch and shift the alarm |
| win_we_i | input | 1 | Window write enable |
| win_addr_i | input | 4 | Window entry address |
| win_wdata_i | input | 4 | Window write data |
| win_rdata_o | output | 4 | Window read data, combinational on the address |
| min_o | output | 11 | Current minute of day |
| day_o | output | 12 | Current day count |

## Verification
Every result of a tick, latch, load or window write is registered, so it appears exactly one clock edge after the request. Window reads follow the address combinationally in the same cycle. The bench drives each request on a falling edge and drops it on the next falling edge, so exactly one rising edge falls in between. It then samples counters and window data after that falling edge, with reads settled for 1 ns after the address changes. Alarm shift cases come from a vector table. The bench loads an old time, writes an alarm, loads a new time, and reads the alarm back one cycle later.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  localparam int NYB_W = 4;
  typedef logic [NYB_W-1:0] nyb_t;
endpackage

// File: rtl/mdc_counter.sv
module mdc_counter #(
  parameter int MINS_PER_DAY = 1440,
  parameter int MIN_W        = 11,
  parameter int DAY_W        = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [MIN_W-1:0] load_min_i,
  input  logic [DAY_W-1:0] load_day_i,
  output logic [MIN_W-1:0] min_o,
  output logic [DAY_W-1:0] day_o
);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MINS_PER_DAY - 1);
  localparam logic [DAY_W-1:0] DAY_MAX  = {DAY_W{1'b1}};

  logic [MIN_W-1:0] min_q, min_d;
  logic [DAY_W-1:0] day_q, day_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | tick_i;
    min_d  = min_q;
    day_d  = day_q;
    if (load_i) begin
      min_d = load_min_i;
      day_d = load_day_i;
    end else if (tick_i) begin
      if (min_q == MIN_LAST) begin
        min_d = '0;
        if (day_q != DAY_MAX) day_d = day_q + 1'b1;
      end else begin
        min_d = min_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '0;
      day_q <= '0;
    end else if (cnt_en) begin
      min_q <= min_d;
      day_q <= day_d;
    end
  end

  assign min_o = min_q;
  assign day_o = day_q;

  AST_MIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    min_o <= MIN_LAST);  // R1
  AST_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && min_o == MIN_LAST) |=> (min_o == '0));  // R2
  AST_DAY_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (day_o == DAY_MAX && !load_i) |=> (day_o == DAY_MAX));  // R3
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (min_o == $past(load_min_i) && day_o == $past(load_day_i)));  // R9
endmodule

// File: rtl/mdc_alarm_shift.sv
module mdc_alarm_shift #(
  parameter int MINS_PER_DAY = 1440,
  parameter int MIN_W        = 11,
  parameter int MFLD_W       = 12,
  parameter int DAY_W        = 12
) (
  input  logic [MIN_W-1:0]  old_min_i,
  input  logic [DAY_W-1:0]  old_day_i,
  input  logic [MIN_W-1:0]  new_min_i,
  input  logic [DAY_W-1:0]  new_day_i,
  input  logic [MFLD_W-1:0] alm_min_i,
  input  logic [DAY_W-1:0]  alm_day_i,
  output logic [MFLD_W-1:0] alm_min_o,
  output logic [DAY_W-1:0]  alm_day_o
);
  localparam int SW = MFLD_W + 2;
  localparam logic signed [SW-1:0] MPD_S = SW'(MINS_PER_DAY);

  logic signed [SW-1:0] raw_sum, adj_sum;
  logic [DAY_W-1:0]     day_adj;

  always_comb begin
    raw_sum = $signed({2'b00, alm_min_i})
            + $signed({{(SW-MIN_W){1'b0}}, new_min_i})
            - $signed({{(SW-MIN_W){1'b0}}, old_min_i});
    adj_sum = raw_sum;
    day_adj = '0;
    if (raw_sum < 0) begin
      adj_sum = raw_sum + MPD_S;
      day_adj = {DAY_W{1'b1}};
    end else if (raw_sum >= MPD_S) begin
      adj_sum = raw_sum - MPD_S;
      day_adj = DAY_W'(1);
    end
    alm_min_o = adj_sum[MFLD_W-1:0];
    alm_day_o = alm_day_i + new_day_i - old_day_i + day_adj;
  end
endmodule

// File: rtl/mdc_window.sv
module mdc_window
  import mdc_pkg::*;
#(
  parameter int SCR_N  = 6,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  nyb_t                   wdata_i,
  output nyb_t                   rdata_o,
  input  logic                   cap_i,
  input  logic [SCR_N*NYB_W-1:0] cap_nyb_i,
  input  logic                   alm_upd_i,
  input  logic [SCR_N*NYB_W-1:0] alm_nyb_i,
  output logic [SCR_N*NYB_W-1:0] scr_o,
  output logic [SCR_N*NYB_W-1:0] alm_o
);
  localparam int WIN_N = 2 * SCR_N;

  nyb_t ent_q [WIN_N];

  for (genvar i = 0; i < WIN_N; i++) begin : g_ent
    logic ent_en;
    nyb_t ent_d;
    logic hit;
    assign hit = we_i && (addr_i == ADDR_W'(i));
    if (i < SCR_N) begin : g_scr
      always_comb begin
        ent_en = cap_i | hit;
        ent_d  = cap_i ? cap_nyb_i[i*NYB_W +: NYB_W] : wdata_i;
      end
      assign scr_o[i*NYB_W +: NYB_W] = ent_q[i];
    end else begin : g_alm
      always_comb begin
        ent_en = alm_upd_i | hit;
        ent_d  = alm_upd_i ? alm_nyb_i[(i-SCR_N)*NYB_W +: NYB_W] : wdata_i;
      end
      assign alm_o[(i-SCR_N)*NYB_W +: NYB_W] = ent_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[i] <= '0;
      else if (ent_en) ent_q[i] <= ent_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < WIN_N; k++) begin
      if (addr_i == ADDR_W'(k)) rdata_o = ent_q[k];
    end
  end

  logic alm_wr;
  assign alm_wr = we_i && (addr_i >= ADDR_W'(SCR_N)) && (addr_i < ADDR_W'(WIN_N));

  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (scr_o == $past(cap_nyb_i)));  // R4
  AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!alm_upd_i && !alm_wr) |=> $stable(alm_o));  // R8
endmodule

// File: rtl/mdc_clock.sv
module mdc_clock
  import mdc_pkg::*;
#(
  parameter int MINS_PER_DAY = 1440,
  parameter int DAY_NYB      = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        latch_i,
  input  logic        load_i,
  input  logic        win_we_i,
  input  logic [3:0]  win_addr_i,
  input  logic [3:0]  win_wdata_i,
  output logic [3:0]  win_rdata_o,
  output logic [10:0] min_o,
  output logic [11:0] day_o
);
  localparam int MIN_W   = $clog2(MINS_PER_DAY);
  localparam int MIN_NYB = (MIN_W + NYB_W - 1) / NYB_W;
  localparam int MFLD_W  = MIN_NYB * NYB_W;
  localparam int DAY_W   = DAY_NYB * NYB_W;
  localparam int SCR_N   = MIN_NYB + DAY_NYB;
  localparam int ADDR_W  = $clog2(2 * SCR_N);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [MIN_W-1:0]       cur_min, new_min;
  logic [DAY_W-1:0]       cur_day, new_day;
  logic [SCR_N*NYB_W-1:0] cap_bus, scr_bus, alm_bus, alm_nxt;
  logic [MFLD_W-1:0]      scr_min, alm_min_nxt;
  logic [DAY_W-1:0]       alm_day_nxt;
  logic                   latch_eff;

  assign latch_eff = latch_i & ~load_i;
  assign cap_bus   = {cur_day, MFLD_W'(cur_min)};
  assign scr_min   = scr_bus[MFLD_W-1:0];
  assign new_day   = scr_bus[SCR_N*NYB_W-1 -: DAY_W];
  assign new_min   = (scr_min >= MFLD_W'(MINS_PER_DAY)) ? MIN_W'(MINS_PER_DAY - 1)
                                                        : scr_min[MIN_W-1:0];
  assign alm_nxt   = {alm_day_nxt, alm_min_nxt};

  mdc_counter #(.MINS_PER_DAY(MINS_PER_DAY), .MIN_W(MIN_W), .DAY_W(DAY_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .load_i     (load_i),
    .load_min_i (new_min),
    .load_day_i (new_day),
    .min_o      (cur_min),
    .day_o      (cur_day)
  );

  mdc_alarm_shift #(.MINS_PER_DAY(MINS_PER_DAY), .MIN_W(MIN_W), .MFLD_W(MFLD_W),
                    .DAY_W(DAY_W)) u_shift (
    .old_min_i (cur_min),
    .old_day_i (cur_day),
    .new_min_i (new_min),
    .new_day_i (new_day),
    .alm_min_i (alm_bus[MFLD_W-1:0]),
    .alm_day_i (alm_bus[SCR_N*NYB_W-1 -: DAY_W]),
    .alm_min_o (alm_min_nxt),
    .alm_day_o (alm_day_nxt)
  );

  mdc_window #(.SCR_N(SCR_N), .ADDR_W(ADDR_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we_i      (win_we_i),
    .addr_i    (win_addr_i[ADDR_W-1:0]),
    .wdata_i   (win_wdata_i),
    .rdata_o   (win_rdata_o),
    .cap_i     (latch_eff),
    .cap_nyb_i (cap_bus),
    .alm_upd_i (load_i),
    .alm_nyb_i (alm_nxt),
    .scr_o     (scr_bus),
    .alm_o     (alm_bus)
  );

  assign min_o = cur_min;
  assign day_o = cur_day;
endmodule

// File: tb/mdc_clock_tb.sv
`timescale 1ns/1ps
module mdc_clock_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, latch = 1'b0, load = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0, wdata = '0, rdata;
  logic [10:0] min_o;
  logic [11:0] day_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  mdc_clock u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .latch_i(latch), .load_i(load),
    .win_we_i(we), .win_addr_i(addr), .win_wdata_i(wdata), .win_rdata_o(rdata),
    .min_o(min_o), .day_o(day_o)
  );

  // {old_min, old_day, alarm_min, alarm_day, new_min, new_day, exp_alarm_min, exp_alarm_day}
  localparam logic [95:0] VEC [8] = '{
    {12'd100,  12'd5,    12'd200,  12'd10,   12'd110,  12'd5,    12'd210,  12'd10},
    {12'd1430, 12'd0,    12'd1435, 12'd3,    12'd10,   12'd1,    12'd15,   12'd4},
    {12'd600,  12'd20,   12'd100,  12'd20,   12'd500,  12'd20,   12'd0,    12'd20},
    {12'd600,  12'd20,   12'd50,   12'd20,   12'd500,  12'd20,   12'd1390, 12'd19},
    {12'd0,    12'd0,    12'd1439, 12'd0,    12'd1,    12'd0,    12'd0,    12'd1},
    {12'd0,    12'd10,   12'd0,    12'd2,    12'd0,    12'd0,    12'd0,    12'd4088},
    {12'd5,    12'd4095, 12'd20,   12'd4095, 12'd5,    12'd0,    12'd20,   12'd0},
    {12'd1000, 12'd100,  12'd1000, 12'd100,  12'd1500, 12'd100,  12'd1439, 12'd100}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic l, input logic ld);
    @(negedge clk); tick = t; latch = l; load = ld;
    @(negedge clk); tick = 1'b0; latch = 1'b0; load = 1'b0;
  endtask

  task automatic wr(input int a, input logic [3:0] d);
    @(negedge clk); we = 1'b1; addr = a[3:0]; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [3:0] d);
    @(negedge clk); addr = a[3:0]; #1; d = rdata;
  endtask

  task automatic wr_field(input int base, input logic [11:0] v);
    for (int k = 0; k < 3; k++) wr(base + k, v[4*k +: 4]);
  endtask

  task automatic rd_field(input int base, output logic [11:0] v);
    logic [3:0] n;
    for (int k = 0; k < 3; k++) begin
      rd(base + k, n);
      v[4*k +: 4] = n;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] f, g;
    logic [3:0]  n;
    int          bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 reset min", min_o, 0);
    chk("R1 reset day", day_o, 0);
    bad = 0;
    for (int a = 0; a < 16; a++) begin rd(a, n); if (n != 0) bad++; end
    chk("R1 reset window", bad, 0);

    // R1 counting
    repeat (3) step(1, 0, 0);
    chk("R1 three ticks", min_o, 3);

    // R4 latch layout
    step(0, 1, 0);
    rd_field(0, f); chk("R4 latch minute", f, 3);
    rd_field(3, f); chk("R4 latch day", f, 0);

    // R4 latch with tick: pre-tick snapshot, tick counted
    step(1, 1, 0);
    rd_field(0, f); chk("R4 latch+tick snapshot", f, 3);
    chk("R4 latch+tick counter", min_o, 4);

    // R8 alarm unmoved by ticks and latch
    wr_field(6, 12'd77); wr_field(9, 12'd9);
    repeat (5) step(1, 0, 0);
    step(0, 1, 0);
    rd_field(6, f); rd_field(9, g);
    chk("R8 alarm minute hold", f, 77);
    chk("R8 alarm day hold", g, 9);

    // R2 rollover
    wr_field(0, 12'd1439); wr_field(3, 12'd7);
    step(0, 0, 1);
    chk("R6 load minute", min_o, 1439);
    step(1, 0, 0);
    chk("R2 rollover minute", min_o, 0);
    chk("R2 rollover day", day_o, 8);

    // R3 saturation
    wr_field(0, 12'd1439); wr_field(3, 12'd4095);
    step(0, 0, 1);
    step(1, 0, 0);
    chk("R3 sat minute", min_o, 0);
    chk("R3 sat day", day_o, 4095);
    step(1, 0, 0);
    chk("R3 sat next", day_o, 4095);

    // R9 load beats tick
    wr_field(0, 12'd50); wr_field(3, 12'd2);
    step(1, 0, 1);
    chk("R9 load+tick minute", min_o, 50);
    chk("R9 load+tick day", day_o, 2);

    // R5 high addresses
    wr(12, 4'h5); wr(15, 4'hA);
    rd(12, n); chk("R5 addr12 reads zero", n, 0);
    rd(15, n); chk("R5 addr15 reads zero", n, 0);
    rd_field(0, f); chk("R5 scratch untouched", f, 50);
    rd(11, n); wr(11, 4'hC); rd(11, n); chk("R5 addr11 write/read", n, 12);

    // R10 load with latch
    wr_field(0, 12'd60); wr_field(3, 12'd3);
    step(1, 1, 1);
    chk("R10 load+latch minute", min_o, 60);
    rd_field(0, f); chk("R10 scratch keeps loaded", f, 60);

    // R7 / R6 vector table
    foreach (VEC[i]) begin
      logic [11:0] om, od, am, ad, nm, nd, em, ed;
      {om, od, am, ad, nm, nd, em, ed} = VEC[i];
      wr_field(0, om); wr_field(3, od);
      step(0, 0, 1);
      wr_field(6, am); wr_field(9, ad);
      wr_field(0, nm); wr_field(3, nd);
      step(0, 0, 1);
      chk($sformatf("R6 vec%0d minute", i), min_o, (nm >= 1440) ? 1439 : int'(nm));
      chk($sformatf("R6 vec%0d day", i), day_o, nd);
      rd_field(6, f); rd_field(9, g);
      chk($sformatf("R7 vec%0d alarm minute", i), f, em);
      chk($sformatf("R7 vec%0d alarm day", i), g, ed);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule